// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Neuron

This block is one spiking neuron. Its membrane voltage is a signed 16-bit value with 8 fractional bits, so 0x0100 stands for 1.0. On each clock where the step strobe is high, the neuron does four things in one update:

- It scales the stored voltage by a programmable leak factor, using a full-width product.
- It adds the input current.
- It limits both intermediate results to the signed 16-bit range.
- It compares the new voltage with a fixed threshold of 1.0.

If the threshold is reached, the neuron emits a one-clock spike and the voltage returns to zero. Otherwise the new voltage is stored.

Each intermediate value follows one fixed sequence: multiply, realign, clamp, add, clamp. A software model that uses the same sequence therefore reproduces the hardware bit for bit. A surrounding system pulses the step strobe once per simulation time step. Between steps it may change the current and the leak factor freely.

Top module: `lif_neuron`

## Requirements
- R1: While `rst_n` is low, `v_mem` is 0 and `spike` is 0 after the next clock edge.
- R2: On a clock edge with `step` low, `v_mem` keeps its value and `spike` is 0, whatever `i_cur` and `leak_k` are.
- R3: On a step, the leak term is the signed 32-bit product `leak_k * v_mem` arithmetically shifted right by 8, which rounds toward minus infinity (for example v=-500, k=77 gives -151), when that result fits in a signed 16-bit value.
- R4: When the product exceeds 0x007FFFFF, the leak term becomes 0x7FFF (+32767).
- R5: When the product is below -0x00800000, the leak term becomes 0x8000 (-32768).
- R6: The sum of the leak term and `i_cur` is a signed addition that clamps to [-32768, 32767] and never wraps.
- R7: When the clamped sum, taken as signed, is at least 256, the step sets `spike` to 1 and `v_mem` to 0. Otherwise `v_mem` takes the sum and `spike` is 0. The stored voltage is therefore always below 256.
- R8: `spike` is high for exactly the one clock that follows a firing step. A step that does not fire, or a clock with no step, sets it low.
- R9: Each step updates `v_mem` and `spike` on the clock edge where `step` is sampled high. Over any sequence of steps and idle clocks, the outputs agree bit for bit with a model that uses the R3–R7 order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Performs one neuron update on this edge when high |
| i_cur | input | 16 | Input current, signed Q8.8 |
| leak_k | input | 16 | Leak factor, signed Q8.8 |
| spike | output | 1 | One-clock spike pulse |
| v_mem | output | 16 | Membrane voltage, signed Q8.8 |

## Verification
The bench targets four weak spots:

- **Rounding of negative leak products.** Truncating toward zero instead of flooring leaves the voltage one LSB too high.
- **Both clamp limits on the product.** If bits [23:8] are taken without clamping, a product of 2^30 collapses to zero and a large negative product turns into a small value.
- **Adder saturation in both directions.** A wrapping adder turns an overflowed positive sum into a negative voltage with no spike, and a negative overflow into a large positive one.
- **The exact threshold.** A strict comparison misses the spike at exactly 256.

Idle clocks with changing inputs show whether the hold path leaks stimulus into the state. A long mixed run against the bench's own integer model catches any ordering error between clamping and adding.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int LIF_WIDTH = 16;
  localparam int LIF_FRAC  = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INTEG = 2'd1,
    ACT_FIRE  = 2'd2
  } lif_act_e;
endpackage

// File: rtl/lif_leak_mul.sv
module lif_leak_mul #(
  parameter int WIDTH = lif_pkg::LIF_WIDTH,
  parameter int FRAC  = lif_pkg::LIF_FRAC
) (
  input  logic signed [WIDTH-1:0] volt,
  input  logic signed [WIDTH-1:0] factor,
  output logic signed [WIDTH-1:0] leak
);
  localparam int PW = 2 * WIDTH;
  localparam int KEEP = WIDTH - 1 + FRAC;
  localparam logic signed [PW-1:0] HI_LIM = {{(PW-KEEP){1'b0}}, {KEEP{1'b1}}};
  localparam logic signed [PW-1:0] LO_LIM = {{(PW-KEEP){1'b1}}, {KEEP{1'b0}}};
  localparam logic signed [WIDTH-1:0] Q_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] Q_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  // full-width signed product, then realign and clamp
  function automatic logic signed [WIDTH-1:0] scale_clamp(
    input logic signed [WIDTH-1:0] a,
    input logic signed [WIDTH-1:0] b
  );
    logic signed [PW-1:0] ae;
    logic signed [PW-1:0] be;
    logic signed [PW-1:0] prod;
    ae   = {{WIDTH{a[WIDTH-1]}}, a};
    be   = {{WIDTH{b[WIDTH-1]}}, b};
    prod = ae * be;
    if (prod > HI_LIM)      scale_clamp = Q_MAX;
    else if (prod < LO_LIM) scale_clamp = Q_MIN;
    else                    scale_clamp = prod[KEEP:FRAC];
  endfunction

  always_comb leak = scale_clamp(volt, factor);
endmodule

// File: rtl/lif_sat_add.sv
module lif_sat_add #(
  parameter int WIDTH = lif_pkg::LIF_WIDTH
) (
  input  logic signed [WIDTH-1:0] op_a,
  input  logic signed [WIDTH-1:0] op_b,
  output logic signed [WIDTH-1:0] total
);
  // one guard bit detects overflow; clamp toward its sign
  function automatic logic signed [WIDTH-1:0] add_clamp(
    input logic signed [WIDTH-1:0] a,
    input logic signed [WIDTH-1:0] b
  );
    logic [WIDTH:0] s;
    s = {a[WIDTH-1], a} + {b[WIDTH-1], b};
    if (s[WIDTH] != s[WIDTH-1])
      add_clamp = s[WIDTH] ? {1'b1, {(WIDTH-1){1'b0}}} : {1'b0, {(WIDTH-1){1'b1}}};
    else
      add_clamp = s[WIDTH-1:0];
  endfunction

  always_comb total = add_clamp(op_a, op_b);
endmodule

// File: rtl/lif_fire_cmp.sv
module lif_fire_cmp #(
  parameter int WIDTH = lif_pkg::LIF_WIDTH,
  parameter int FRAC  = lif_pkg::LIF_FRAC
) (
  input  logic signed [WIDTH-1:0] cand,
  output logic                    fire
);
  localparam logic signed [WIDTH-1:0] THRESH = {{(WIDTH-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  always_comb fire = (cand >= THRESH);
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int WIDTH = lif_pkg::LIF_WIDTH,
  parameter int FRAC  = lif_pkg::LIF_FRAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIDTH-1:0] i_cur,
  input  logic [WIDTH-1:0] leak_k,
  output logic             spike,
  output logic [WIDTH-1:0] v_mem
);
  import lif_pkg::*;

  logic signed [WIDTH-1:0] v_q;
  logic                    spike_q;
  logic signed [WIDTH-1:0] leak_term;
  logic signed [WIDTH-1:0] sum_term;
  logic                    fire_now;
  lif_act_e                act;

  lif_leak_mul #(.WIDTH(WIDTH), .FRAC(FRAC)) u_leak (
    .volt   (v_q),
    .factor ($signed(leak_k)),
    .leak   (leak_term)
  );

  lif_sat_add #(.WIDTH(WIDTH)) u_add (
    .op_a  (leak_term),
    .op_b  ($signed(i_cur)),
    .total (sum_term)
  );

  lif_fire_cmp #(.WIDTH(WIDTH), .FRAC(FRAC)) u_cmp (
    .cand (sum_term),
    .fire (fire_now)
  );

  always_comb begin
    if (!step)        act = ACT_HOLD;
    else if (fire_now) act = ACT_FIRE;
    else              act = ACT_INTEG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= '0;
      spike_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_FIRE: begin
          v_q     <= '0;
          spike_q <= 1'b1;
        end
        ACT_INTEG: begin
          v_q     <= sum_term;
          spike_q <= 1'b0;
        end
        default: spike_q <= 1'b0;
      endcase
    end
  end

  assign v_mem = v_q;
  assign spike = spike_q;
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk #(
  parameter int WIDTH = lif_pkg::LIF_WIDTH,
  parameter int FRAC  = lif_pkg::LIF_FRAC
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step,
  input logic [WIDTH-1:0]        i_cur,
  input logic [WIDTH-1:0]        leak_k,
  input logic                    spike,
  input logic [WIDTH-1:0]        v_mem,
  input logic signed [WIDTH-1:0] leak_term,
  input logic signed [WIDTH-1:0] sum_term
);
  localparam logic signed [WIDTH-1:0] THRESH = {{(WIDTH-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (v_mem == '0 && !spike));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(v_mem) && !spike));

  // R4
  leak_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_k[WIDTH-1] == v_mem[WIDTH-1]) |-> !leak_term[WIDTH-1]);

  // R6
  add_no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!leak_term[WIDTH-1] && !i_cur[WIDTH-1]) |-> !sum_term[WIDTH-1]);

  // R6
  add_no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_term[WIDTH-1] && i_cur[WIDTH-1]) |-> sum_term[WIDTH-1]);

  // R7
  spike_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> (v_mem == '0));

  // R7
  below_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(v_mem) < THRESH);

  // R8
  spike_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(step));
endmodule

bind lif_neuron lif_neuron_chk #(.WIDTH(WIDTH), .FRAC(FRAC)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .i_cur     (i_cur),
  .leak_k    (leak_k),
  .spike     (spike),
  .v_mem     (v_mem),
  .leak_term (leak_term),
  .sum_term  (sum_term)
);

// File: tb/test_lif_neuron.sv
`timescale 1ns/1ps
module test_lif_neuron;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [15:0] i_cur = '0;
  logic [15:0] leak_k = '0;
  logic        spike;
  logic [15:0] v_mem;

  int  n_chk = 0;
  int  n_fail = 0;
  int  m_v = 0;
  bit  finished = 0;

  lif_neuron i_lif_neuron (
    .clk(clk), .rst_n(rst_n), .step(step), .i_cur(i_cur),
    .leak_k(leak_k), .spike(spike), .v_mem(v_mem)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clamp16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  // integer restatement of the requirement order: multiply, floor, clamp, add, clamp
  function automatic void ref_step(input int v, input int k, input int i,
                                   output int nv, output bit sp);
    longint p;
    int l;
    int s;
    p = longint'(v) * longint'(k);
    if (p >= 0) l = clamp16(p / 256);
    else        l = clamp16(-((-p + 255) / 256));
    s = clamp16(longint'(l) + longint'(i));
    if (s >= 256) begin nv = 0; sp = 1; end
    else begin nv = s; sp = 0; end
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input int ev, input bit es);
    check($signed(v_mem) == ev, {tag, " v_mem"}, $signed(v_mem), ev);
    check(spike == es, {tag, " spike"}, int'(spike), int'(es));
  endtask

  // one step at the current negedge; outputs checked at the following negedge
  task automatic do_step(input int k, input int i, input string tag);
    int nv;
    bit sp;
    ref_step(m_v, k, i, nv, sp);
    step = 1'b1; leak_k = 16'(k); i_cur = 16'(i);
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    m_v = nv;
    check_out(tag, nv, sp);
  endtask

  task automatic idle(input int k, input int i, input string tag);
    step = 1'b0; leak_k = 16'(k); i_cur = 16'(i);
    @(posedge clk);
    @(negedge clk);
    check_out(tag, m_v, 1'b0);
  endtask

  task automatic set_v(input int target);
    do_step(0, target, "setup");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 0, 1'b0);
    rst_n = 1'b1;
    m_v = 0;
    @(negedge clk);
    check_out("R1 after release", 0, 1'b0);
  endtask

  task automatic t_hold();
    set_v(-1234);
    idle(32767, 32767, "R2 idle big");
    idle(-32768, -32768, "R2 idle neg");
    idle(256, 500, "R2 idle fire-level");
    check($signed(v_mem) == -1234, "R2 held value", $signed(v_mem), -1234);
  endtask

  task automatic t_leak_floor();
    set_v(-1000);
    do_step(128, 0, "R3 half leak");
    check($signed(v_mem) == -500, "R3 -1000*0.5", $signed(v_mem), -500);
    do_step(77, 0, "R3 floor");
    check($signed(v_mem) == -151, "R3 floor -500*77", $signed(v_mem), -151);
    set_v(200);
    do_step(200, 0, "R3 positive");
    check($signed(v_mem) == 156, "R3 200*200", $signed(v_mem), 156);
  endtask

  task automatic t_clip_hi();
    set_v(-32768);
    do_step(-32768, -32512, "R4 clamp hi");
    check($signed(v_mem) == 255, "R4 0x7FFF-0x7F00", $signed(v_mem), 255);
  endtask

  task automatic t_clip_lo();
    set_v(-32768);
    do_step(32767, 100, "R5 clamp lo");
    check($signed(v_mem) == -32668, "R5 0x8000+100", $signed(v_mem), -32668);
  endtask

  task automatic t_add_sat();
    set_v(-32768);
    do_step(256, -1, "R6 neg sat");
    check($signed(v_mem) == -32768, "R6 neg clamp", $signed(v_mem), -32768);
    set_v(-32768);
    do_step(-32768, 32767, "R6 pos sat");
    check(spike == 1'b1, "R6 pos clamp fires", int'(spike), 1);
  endtask

  task automatic t_threshold();
    set_v(0);
    do_step(256, 255, "R7 just below");
    check($signed(v_mem) == 255, "R7 255 kept", $signed(v_mem), 255);
    set_v(0);
    do_step(256, 256, "R7 exact threshold");
    check(spike == 1'b1 && v_mem == 0, "R7 fire at 256", int'(spike), 1);
  endtask

  task automatic t_pulse();
    set_v(0);
    do_step(0, 300, "R8 fire");
    idle(0, 300, "R8 pulse ends");
    do_step(0, 300, "R8 refire");
    do_step(0, 10, "R8 no fire clears");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      int k;
      int i;
      int sel;
      sel = int'($urandom_range(0, 3));
      k = (sel == 0) ? int'($signed(16'($urandom))) : int'($urandom_range(0, 300)) - 40;
      i = (sel == 1) ? int'($signed(16'($urandom))) : int'($urandom_range(0, 400)) - 250;
      if ($urandom_range(0, 4) == 0) idle(k, i, "R9 random idle");
      else do_step(k, i, "R9 random step");
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_leak_floor();
    t_clip_hi();
    t_clip_lo();
    t_add_sat();
    t_threshold();
    t_pulse();
    t_random();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule